// File: doc/BRIEF.md
# Vertical-Blank Interrupt Scheduler and Status Flags

This block watches the raster position of a video timing generator and produces the frame-rate interrupt for the main processor. When the line counter enters the blanking region, the block latches a vertical-blank flag and, if the host has enabled the interrupt, arms a pending request with a deadline expressed in master cycles. The request does not fire immediately. It fires when the in-line cycle position reaches the deadline. At every later line wrap the deadline is moved back by the length of the line just finished, so a deadline that lies beyond the current line is still honoured correctly on the following line.

The block also produces a one-cycle controller auto-read strobe a few lines into blanking, flips a field-parity bit at every frame boundary, and wakes a processor that is halted waiting for an interrupt. With the wake pulse it reports the extra master-cycle penalty the processor must spend. The host reads the status byte through a read strobe. A read clears the blanking flag but returns the value it had before the read.

The interrupt scheduler is a two-state machine. State `NS_IDLE` means no request is outstanding; transition ARM (vertical-blank line reached with the enable bit set) moves it to `NS_ARMED`. In `NS_ARMED`, transition REARM (another arming wrap) reloads the deadline, transition REBASE (a plain line wrap) shifts the deadline, and transition FIRE (cycle position at or past the deadline, outside a wrap cycle) returns to `NS_IDLE` and emits the pulse.

Top module: `vbl_nmi_top`

## Requirements
- R1: Status byte layout: bit 7 is the blanking flag, bits 6:0 always hold the revision code (default 2). A line wrap onto line visible-height + 1 sets bit 7 (read value 0x82 with the default code).
- R2: A line wrap onto line 0 clears bit 7 of the status byte (read value 0x02).
- R3: On the wrap that sets the blanking flag, if bit 7 of the interrupt-control input is 1, the interrupt becomes pending on the next cycle with a deadline of master cycle 12; if that bit is 0, nothing becomes pending.
- R4: While pending, in a cycle without a line wrap where the cycle position is greater than or equal to the deadline, a one-cycle fire pulse is produced on the next cycle and pending clears in that same cycle. A position below the deadline produces no pulse.
- R5: At each line wrap while pending (other than the arming wrap), the deadline is reduced by the line-length input, so a position lower than 12 may fire on the following line.
- R6: If the core-halted input is 1 in the cycle the interrupt fires, a one-cycle wake pulse accompanies the fire pulse and the wake-delay output reads 14 (two 6-cycle processor cycles plus half a 4-cycle dot); otherwise the wake-delay output reads 0.
- R7: A line wrap onto line visible-height + 3 with bit 0 of the interrupt-control input set produces a one-cycle auto-read pulse; with bit 0 clear there is none.
- R8: Every line wrap onto line 0 inverts the field-parity output.
- R9: A status read returns the current byte and clears bit 7 on the following cycle; a blanking-start wrap in the same cycle as a read leaves bit 7 set.
- R10: The tall-mode input selects a visible height of 239 lines (blanking at line 240, auto-read at 242) instead of 224 (blanking at 225, auto-read at 227).
- R11: Synchronous active-high reset clears pending, the deadline (to the idle sentinel 0xFFFF), the blanking flag, field parity and all pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_num_i | input | 9 | Line number; on a wrap cycle it is the line being entered |
| line_wrap_i | input | 1 | One-cycle strobe marking a line boundary |
| cycle_pos_i | input | 16 | Master-cycle position within the current line |
| line_len_i | input | 16 | Length in master cycles of the line just finished |
| tall_mode_i | input | 1 | 1 selects 239 visible lines, 0 selects 224 |
| irq_ctrl_i | input | 8 | Host interrupt-control byte: bit 7 interrupt enable, bit 0 auto-read enable |
| core_halted_i | input | 1 | Processor is halted waiting for an interrupt |
| status_rd_i | input | 1 | Host read of the status byte |
| nmi_pending_o | output | 1 | Interrupt armed and not yet fired |
| nmi_fire_o | output | 1 | One-cycle interrupt assertion pulse |
| core_wake_o | output | 1 | One-cycle release of a halted processor |
| wake_delay_o | output | 8 | Extra master cycles charged on wake, 0 otherwise |
| vb_status_o | output | 8 | Status byte: blanking flag and revision code |
| pad_read_o | output | 1 | One-cycle controller auto-read strobe |
| field_parity_o | output | 1 | Field parity, inverted each frame |

## Verification
On every cycle the assertions hold the scheduler to its rules: a fire pulse only follows a pending cycle and leaves nothing pending, a wake pulse never appears without a fire pulse, arming always yields pending, and the blanking flag, frame clear, read clear and parity flip follow their triggering wraps. What only the bench scenarios can show is the arithmetic of the deadline: that the first fire happens exactly at position 12, that rebasing by the line length lets a low position fire on the next line, and that the blanking and auto-read lines move with the height mode. The pre-clear value of a read, the set-over-clear priority and the cancelling of an armed request by reset are likewise shown by directed scenarios.

// File: rtl/vbl_pkg.sv
package vbl_pkg;

    typedef enum logic [0:0] {
        NS_IDLE  = 1'b0,
        NS_ARMED = 1'b1
    } nmi_state_e;

    typedef struct packed {
        logic vblank;   // wrap onto the first blanking line
        logic frame;    // wrap onto line 0
        logic pad;      // wrap onto the auto-read line with auto-read enabled
    } line_evt_t;

endpackage

// File: rtl/vbl_line_decode.sv
module vbl_line_decode
    import vbl_pkg::*;
#(
    parameter int LINE_W     = 9,
    parameter int H_SHORT    = 224,
    parameter int H_TALL     = 239,
    parameter int FIRST_LINE = 1,
    parameter int PAD_OFS    = 3
) (
    input  logic [LINE_W-1:0] line_num_i,
    input  logic              line_wrap_i,
    input  logic              tall_mode_i,
    input  logic              pad_en_i,
    output line_evt_t         evt_o
);
    localparam logic [LINE_W-1:0] VB_SHORT  = LINE_W'(H_SHORT + FIRST_LINE);
    localparam logic [LINE_W-1:0] VB_TALL   = LINE_W'(H_TALL + FIRST_LINE);
    localparam logic [LINE_W-1:0] PAD_SHORT = LINE_W'(H_SHORT + PAD_OFS);
    localparam logic [LINE_W-1:0] PAD_TALL  = LINE_W'(H_TALL + PAD_OFS);

    logic [LINE_W-1:0] vb_line;
    logic [LINE_W-1:0] pad_line;

    always_comb begin
        vb_line  = tall_mode_i ? VB_TALL  : VB_SHORT;
        pad_line = tall_mode_i ? PAD_TALL : PAD_SHORT;
        evt_o.vblank = line_wrap_i && (line_num_i == vb_line);
        evt_o.frame  = line_wrap_i && (line_num_i == '0);
        evt_o.pad    = line_wrap_i && pad_en_i && (line_num_i == pad_line);
    end
endmodule

// File: rtl/vbl_status_reg.sv
module vbl_status_reg
    import vbl_pkg::*;
#(
    parameter logic [6:0] REV_CODE = 7'd2
) (
    input  logic      clk,
    input  logic      rst,
    input  line_evt_t evt_i,
    input  logic      rd_i,
    output logic [7:0] status_o,
    output logic      field_o,
    output logic      pad_o
);
    logic vb_q;
    logic field_q;
    logic pad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vb_q    <= 1'b0;
            field_q <= 1'b0;
            pad_q   <= 1'b0;
        end else begin
            // blanking start has priority over a read clear
            if (evt_i.vblank)
                vb_q <= 1'b1;
            else if (evt_i.frame || rd_i)
                vb_q <= 1'b0;
            if (evt_i.frame)
                field_q <= ~field_q;
            pad_q <= evt_i.pad;
        end
    end

    assign status_o = {vb_q, REV_CODE};
    assign field_o  = field_q;
    assign pad_o    = pad_q;

    a_r1_vblank_sets: assert property (@(posedge clk) disable iff (rst)
        evt_i.vblank |=> status_o[7]);
    a_r2_frame_clears: assert property (@(posedge clk) disable iff (rst)
        (evt_i.frame && !evt_i.vblank) |=> !status_o[7]);
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !evt_i.vblank) |=> !status_o[7]);
    a_r8_field_flips: assert property (@(posedge clk) disable iff (rst)
        evt_i.frame |=> (field_o != $past(field_o)));
    a_r7_pad_single: assert property (@(posedge clk) disable iff (rst)
        pad_o |=> !pad_o);
endmodule

// File: rtl/vbl_nmi_sched.sv
module vbl_nmi_sched
    import vbl_pkg::*;
#(
    parameter int CYC_W     = 16,
    parameter int TRIG_INIT = 12,
    parameter int DLY_W     = 8,
    parameter int WAKE_DLY  = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             wrap_i,
    input  logic [CYC_W-1:0] cycle_pos_i,
    input  logic [CYC_W-1:0] line_len_i,
    input  logic             halted_i,
    output logic             pending_o,
    output logic             fire_o,
    output logic             wake_o,
    output logic [DLY_W-1:0] wake_dly_o
);
    localparam int TW = CYC_W + 2;
    localparam logic signed [TW-1:0] SENTINEL = TW'({CYC_W{1'b1}});
    localparam logic signed [TW-1:0] TRIG_VAL = TW'(TRIG_INIT);

    nmi_state_e state_q, state_d;
    logic signed [TW-1:0] trig_q, trig_d;
    logic signed [TW-1:0] pos_s, len_s;
    logic hit;
    logic fire_q, wake_q;

    assign pos_s = $signed({2'b00, cycle_pos_i});
    assign len_s = $signed({2'b00, line_len_i});
    assign hit   = (state_q == NS_ARMED) && !wrap_i && (pos_s >= trig_q);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= NS_IDLE;
            trig_q  <= SENTINEL;
        end else begin
            state_q <= state_d;
            trig_q  <= trig_d;
        end
    end

    // next state and deadline
    always_comb begin
        state_d = state_q;
        trig_d  = trig_q;
        unique case (state_q)
            NS_IDLE: begin
                if (arm_i) begin            // ARM
                    state_d = NS_ARMED;
                    trig_d  = TRIG_VAL;
                end
            end
            NS_ARMED: begin
                if (arm_i) begin            // REARM
                    trig_d = TRIG_VAL;
                end else if (wrap_i) begin  // REBASE
                    trig_d = trig_q - len_s;
                end else if (hit) begin     // FIRE
                    state_d = NS_IDLE;
                    trig_d  = SENTINEL;
                end
            end
            default: begin
                state_d = NS_IDLE;
                trig_d  = SENTINEL;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            fire_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            fire_q <= hit;
            wake_q <= hit && halted_i;
        end
    end

    assign pending_o  = (state_q == NS_ARMED);
    assign fire_o     = fire_q;
    assign wake_o     = wake_q;
    assign wake_dly_o = wake_q ? DLY_W'(WAKE_DLY) : '0;

    a_r4_fire_after_pending: assert property (@(posedge clk) disable iff (rst)
        fire_o |-> $past(pending_o));
    a_r4_fire_clears_pending: assert property (@(posedge clk) disable iff (rst)
        fire_o |-> !pending_o);
    a_r6_wake_with_fire: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> fire_o);
    a_r3_arm_pends: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> pending_o);
    a_r11_idle_sentinel: assert property (@(posedge clk) disable iff (rst)
        !pending_o |-> (trig_q == SENTINEL));
endmodule

// File: rtl/vbl_nmi_top.sv
module vbl_nmi_top
    import vbl_pkg::*;
#(
    parameter int         LINE_W     = 9,
    parameter int         CYC_W      = 16,
    parameter int         DLY_W      = 8,
    parameter int         H_SHORT    = 224,
    parameter int         H_TALL     = 239,
    parameter int         FIRST_LINE = 1,
    parameter int         PAD_OFS    = 3,
    parameter int         TRIG_INIT  = 12,
    parameter int         WAKE_DLY   = 14,
    parameter logic [6:0] REV_CODE   = 7'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line_num_i,
    input  logic              line_wrap_i,
    input  logic [CYC_W-1:0]  cycle_pos_i,
    input  logic [CYC_W-1:0]  line_len_i,
    input  logic              tall_mode_i,
    input  logic [7:0]        irq_ctrl_i,
    input  logic              core_halted_i,
    input  logic              status_rd_i,
    output logic              nmi_pending_o,
    output logic              nmi_fire_o,
    output logic              core_wake_o,
    output logic [DLY_W-1:0]  wake_delay_o,
    output logic [7:0]        vb_status_o,
    output logic              pad_read_o,
    output logic              field_parity_o
);
    line_evt_t evt;
    logic      arm;

    vbl_line_decode #(
        .LINE_W(LINE_W), .H_SHORT(H_SHORT), .H_TALL(H_TALL),
        .FIRST_LINE(FIRST_LINE), .PAD_OFS(PAD_OFS)
    ) u_decode (
        .line_num_i (line_num_i),
        .line_wrap_i(line_wrap_i),
        .tall_mode_i(tall_mode_i),
        .pad_en_i   (irq_ctrl_i[0]),
        .evt_o      (evt)
    );

    assign arm = evt.vblank && irq_ctrl_i[7];

    vbl_status_reg #(.REV_CODE(REV_CODE)) u_status (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .rd_i    (status_rd_i),
        .status_o(vb_status_o),
        .field_o (field_parity_o),
        .pad_o   (pad_read_o)
    );

    vbl_nmi_sched #(
        .CYC_W(CYC_W), .TRIG_INIT(TRIG_INIT), .DLY_W(DLY_W), .WAKE_DLY(WAKE_DLY)
    ) u_sched (
        .clk        (clk),
        .rst        (rst),
        .arm_i      (arm),
        .wrap_i     (line_wrap_i),
        .cycle_pos_i(cycle_pos_i),
        .line_len_i (line_len_i),
        .halted_i   (core_halted_i),
        .pending_o  (nmi_pending_o),
        .fire_o     (nmi_fire_o),
        .wake_o     (core_wake_o),
        .wake_dly_o (wake_delay_o)
    );

    a_r6_wake_delay_value: assert property (@(posedge clk) disable iff (rst)
        core_wake_o |-> (wake_delay_o == DLY_W'(WAKE_DLY)));
endmodule

// File: tb/vbl_nmi_top_tb_top.sv
module vbl_nmi_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  line_num;
    logic        line_wrap;
    logic [15:0] cycle_pos;
    logic [15:0] line_len;
    logic        tall_mode;
    logic [7:0]  irq_ctrl;
    logic        halted;
    logic        rd;
    logic        pend, fire, wake, pad, field;
    logic [7:0]  wdly, stat;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vbl_nmi_top dut_i (
        .clk(clk), .rst(rst), .line_num_i(line_num), .line_wrap_i(line_wrap),
        .cycle_pos_i(cycle_pos), .line_len_i(line_len), .tall_mode_i(tall_mode),
        .irq_ctrl_i(irq_ctrl), .core_halted_i(halted), .status_rd_i(rd),
        .nmi_pending_o(pend), .nmi_fire_o(fire), .core_wake_o(wake),
        .wake_delay_o(wdly), .vb_status_o(stat), .pad_read_o(pad),
        .field_parity_o(field)
    );

    typedef struct packed {
        logic [8:0]  line;
        logic        wrap;
        logic [15:0] pos;
        logic        halt;
        logic        e_pend;
        logic        e_fire;
        logic        e_wake;
        logic [7:0]  e_stat;
        logic        e_pad;
        logic        e_field;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{9'd224, 1'b1, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0},
        '{9'd225, 1'b1, 16'd0,   1'b0, 1'b1, 1'b0, 1'b0, 8'h82, 1'b0, 1'b0},
        '{9'd225, 1'b0, 16'd11,  1'b1, 1'b1, 1'b0, 1'b0, 8'h82, 1'b0, 1'b0},
        '{9'd225, 1'b0, 16'd12,  1'b1, 1'b0, 1'b1, 1'b1, 8'h82, 1'b0, 1'b0},
        '{9'd225, 1'b0, 16'd13,  1'b1, 1'b0, 1'b0, 1'b0, 8'h82, 1'b0, 1'b0},
        '{9'd226, 1'b1, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'h82, 1'b0, 1'b0},
        '{9'd227, 1'b1, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'h82, 1'b1, 1'b0},
        '{9'd227, 1'b0, 16'd5,   1'b0, 1'b0, 1'b0, 1'b0, 8'h82, 1'b0, 1'b0},
        '{9'd0,   1'b1, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b1},
        '{9'd0,   1'b0, 16'd40,  1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b1},
        '{9'd225, 1'b1, 16'd0,   1'b0, 1'b1, 1'b0, 1'b0, 8'h82, 1'b0, 1'b1},
        '{9'd225, 1'b0, 16'd100, 1'b0, 1'b0, 1'b1, 1'b0, 8'h82, 1'b0, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic step(input logic [8:0] ln, input logic wr, input logic [15:0] ps,
                        input logic hl, input logic r);
        line_num = ln; line_wrap = wr; cycle_pos = ps; halted = hl; rd = r;
        @(negedge clk);
        line_wrap = 1'b0; rd = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        line_num = '0; line_wrap = 1'b0; cycle_pos = '0; halted = 1'b0; rd = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        line_len = 16'd1364; tall_mode = 1'b0; irq_ctrl = 8'h81;
        do_reset();

        // R11: reset state
        chk(!pend, "R11 pending", pend, 0);
        chk(!fire && !wake && !pad, "R11 pulses", {fire, wake, pad}, 0);
        chk(stat == 8'h02, "R11 status", stat, 8'h02);
        chk(!field && wdly == 0, "R11 field/delay", {field, wdly}, 0);

        // table walk: one frame's events at default settings
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].line, VECS[i].wrap, VECS[i].pos, VECS[i].halt, 1'b0);
            chk(pend == VECS[i].e_pend, "R3 pending", pend, VECS[i].e_pend);
            chk(fire == VECS[i].e_fire, "R4 fire", fire, VECS[i].e_fire);
            chk(wake == VECS[i].e_wake, "R6 wake", wake, VECS[i].e_wake);
            chk(wdly == (VECS[i].e_wake ? 8'd14 : 8'd0), "R6 delay", wdly,
                VECS[i].e_wake ? 14 : 0);
            chk(stat == VECS[i].e_stat, "R1 R2 status", stat, VECS[i].e_stat);
            chk(pad == VECS[i].e_pad, "R7 pad", pad, VECS[i].e_pad);
            chk(field == VECS[i].e_field, "R8 field", field, VECS[i].e_field);
        end

        // R9: read returns pre-clear value, then clears
        line_num = 9'd226; cycle_pos = 16'd50; rd = 1'b1;
        #1;
        chk(stat == 8'h82, "R9 pre-clear read", stat, 8'h82);
        @(negedge clk); rd = 1'b0;
        chk(stat == 8'h02, "R9 cleared after read", stat, 8'h02);

        // R9: blanking start wins over a same-cycle read
        irq_ctrl = 8'h00;
        step(9'd225, 1'b1, 16'd0, 1'b0, 1'b1);
        chk(stat == 8'h82, "R9 set wins", stat, 8'h82);
        // R3: enable bit 7 clear, no pending
        chk(!pend, "R3 disabled no pending", pend, 0);
        step(9'd225, 1'b0, 16'd500, 1'b0, 1'b0);
        chk(!fire, "R3 disabled no fire", fire, 0);
        // R7: auto-read disabled
        step(9'd226, 1'b1, 16'd0, 1'b0, 1'b0);
        step(9'd227, 1'b1, 16'd0, 1'b0, 1'b0);
        chk(!pad, "R7 disabled no pad", pad, 0);
        // R8 + R2: second frame boundary flips parity back and clears flag
        step(9'd0, 1'b1, 16'd0, 1'b0, 1'b0);
        chk(!field, "R8 field back", field, 0);
        chk(stat == 8'h02, "R2 frame clear", stat, 8'h02);

        // R10: tall mode moves blanking and auto-read lines
        do_reset();
        tall_mode = 1'b1; irq_ctrl = 8'h81;
        step(9'd225, 1'b1, 16'd0, 1'b0, 1'b0);
        chk(stat == 8'h02 && !pend, "R10 no blank at 225", {stat, pend}, 9'h004);
        step(9'd240, 1'b1, 16'd0, 1'b0, 1'b0);
        chk(stat == 8'h82 && pend, "R10 blank at 240", {stat, pend}, 9'h105);
        step(9'd227, 1'b1, 16'd0, 1'b0, 1'b0);
        chk(!pad, "R10 no pad at 227", pad, 0);
        step(9'd242, 1'b1, 16'd0, 1'b0, 1'b0);
        chk(pad, "R10 pad at 242", pad, 1);

        // R5: deadline rebased by line length
        do_reset();
        tall_mode = 1'b0; irq_ctrl = 8'h80; line_len = 16'd10;
        step(9'd225, 1'b1, 16'd0, 1'b0, 1'b0);
        step(9'd225, 1'b0, 16'd3, 1'b0, 1'b0);
        chk(!fire && pend, "R5 below 12 before rebase", {fire, pend}, 1);
        step(9'd226, 1'b1, 16'd0, 1'b0, 1'b0);
        chk(pend && !fire, "R5 still pending across wrap", {fire, pend}, 1);
        step(9'd226, 1'b0, 16'd1, 1'b0, 1'b0);
        chk(!fire, "R5 pos 1 below deadline 2", fire, 0);
        step(9'd226, 1'b0, 16'd3, 1'b0, 1'b0);
        chk(fire && !pend, "R5 fires at pos 3 after rebase", {fire, pend}, 2);
        chk(!wake && wdly == 0, "R6 no wake when running", {wake, wdly}, 0);

        // R11: reset cancels an armed request
        line_len = 16'd1364;
        step(9'd225, 1'b1, 16'd0, 1'b0, 1'b0);
        chk(pend, "R11 armed before reset", pend, 1);
        do_reset();
        chk(!pend, "R11 reset clears pending", pend, 0);
        step(9'd225, 1'b0, 16'd200, 1'b0, 1'b0);
        chk(!fire, "R11 no fire after reset", fire, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule